// File: doc/BRIEF.md
# Polled Byte-Exchange SPI Master (Mode 0)

This block is a byte-wide, full-duplex serial master that sits on a simple CPU load/store bus and is driven entirely by polling. Software writes a byte to the transmit register. The engine then runs eight serial clock cycles. On each cycle it drives one bit onto MOSI and captures one bit from MISO. When the last bit completes, the captured byte is held in a receive register and a data-available flag is raised.

The serial clock idles low and the slave samples on its rising edge. MOSI changes only after a falling edge, except for the first bit, which is presented as soon as the transfer starts. The serial clock half period is a parameter counted in system clocks. With the default of 3, a 25 MHz system clock gives a serial clock of roughly 4.17 MHz. Chip select is not driven here; a separate general-purpose output register drives it. The register bus has no back-pressure: every access completes in the cycle it is presented. Software must therefore poll the status bits before writing or reading.

Top module: `spim_mmio_top`

## Requirements
- R1: After reset, SCLK and MOSI are 0, TX status (offset 0x4, bit 0) reads 1, RX status (offset 0xC, bit 0) reads 0, and the RX data register (offset 0x8) reads 0.
- R2: A write to offset 0x0 while idle starts a transfer of the low byte of write data on the following edge. TX status then reads 0 for the whole exchange.
- R3: Bits leave on MOSI most significant first. MOSI is stable across every SCLK rising edge and changes only after a falling edge.
- R4: SCLK stays low while idle. During a transfer each SCLK high and low phase lasts DIV system clocks, the first rising edge comes DIV clocks after the start edge, and there are exactly 8 rising edges.
- R5: MISO is sampled on SCLK rising edges, most significant bit first. The assembled byte is read zero-extended from offset 0x8.
- R6: The exchange ends 16*DIV clocks after the start edge. On that edge, TX status returns to 1 and RX status becomes 1 together.
- R7: A read of offset 0x8 clears RX status from the next cycle. Reads of any other offset leave it unchanged.
- R8: A write to offset 0x0 while a transfer is running is ignored. The bits sent, the bits received and the finishing cycle are all unchanged.
- R9: When a read of offset 0x8 falls in the cycle a transfer finishes, the read returns the previous byte. RX status stays 1, and the new byte is returned by the next read.
- R10: Reads of unmapped or misaligned offsets (for example 0x10 or 0x2) return 0. Writes to any offset other than 0x0 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | DATA_W | Write data (byte lane) |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | BUS_W | Read data, valid in the cycle bus_re is high, else 0 |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The one collision that matters is a receive-data read landing on the edge where the transfer ends. In that cycle the read tries to clear the data-available flag while completion tries to set it. The bench leaves a first byte unread, starts a second exchange, and issues the read exactly 16*DIV-1 cycles after the start edge, so that the read and completion share one edge. It then expects the old byte from that read, a status of 1 afterwards, and the new byte on the following read. A second, milder overlap (a transmit write arriving mid-shift) is judged by the MOSI stream captured on SCLK rising edges and by the unchanged finishing cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Register slots, decoded from address bits [3:2]; software depends on this layout.
  typedef enum logic [1:0] {
    SLOT_TXD  = 2'd0,  // offset 0x0: write starts an exchange
    SLOT_TXS  = 2'd1,  // offset 0x4: bit 0 = engine idle
    SLOT_RXD  = 2'd2,  // offset 0x8: received byte, read clears flag
    SLOT_RXS  = 2'd3   // offset 0xC: bit 0 = received byte waiting
  } spim_slot_e;
endpackage

// File: rtl/spim_sclk_gen.sv
module spim_sclk_gen #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic tick;

  generate
    if (DIV > 1) begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!active)     cnt <= '0;
        else if (tick)        cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = active && (cnt == CW'(DIV - 1));
    end else begin : g_every
      assign tick = active;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sclk <= 1'b0;
    else if (!active)  sclk <= 1'b0;
    else if (tick)     sclk <= ~sclk;
  end

  assign rise_evt = tick && !sclk;
  assign fall_evt = tick &&  sclk;
endmodule

// File: rtl/spim_shift_core.sv
module spim_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              miso,
  output logic              busy,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [BW-1:0]     bit_idx;

  assign done = busy && fall_evt && (bit_idx == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tx_sh   <= '0;
      bit_idx <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      tx_sh   <= start_data;
      bit_idx <= '0;
    end else if (busy && fall_evt) begin
      if (done) begin
        busy <= 1'b0;
      end else begin
        tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // Capture path: shift in on each serial rising edge, MSB arrives first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rx_sh <= '0;
    else if (busy && rise_evt) rx_sh <= {rx_sh[DATA_W-2:0], miso};
  end

  assign mosi    = busy & tx_sh[DATA_W-1];
  assign rx_byte = rx_sh;
endmodule

// File: rtl/spim_bus_regs.sv
module spim_bus_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [BUS_W-1:0]  rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              start,
  output logic [DATA_W-1:0] start_data,
  output logic              rx_valid,
  output logic              rd_rxd,
  output logic              wr_txd
);
  logic       upper_zero;
  logic       aligned;
  spim_slot_e slot;
  logic [DATA_W-1:0] rx_hold;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:4] == '0);
    end else begin : g_flat
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign slot    = spim_slot_e'(addr[3:2]);
  assign aligned = upper_zero && (addr[1:0] == 2'b00);

  assign wr_txd     = we && aligned && (slot == SLOT_TXD);
  assign rd_rxd     = re && aligned && (slot == SLOT_RXD);
  assign start      = wr_txd && !busy;
  assign start_data = wdata;

  // Completion sets the flag; a data read clears it; completion wins a tie.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_valid <= 1'b0;
    else if (done)    rx_valid <= 1'b1;
    else if (rd_rxd)  rx_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_hold <= '0;
    else if (done) rx_hold <= rx_byte;
  end

  always_comb begin
    rdata = '0;
    if (re && aligned) begin
      unique case (slot)
        SLOT_TXD: rdata = '0;
        SLOT_TXS: rdata = BUS_W'(!busy);
        SLOT_RXD: rdata = BUS_W'(rx_hold);
        SLOT_RXS: rdata = BUS_W'(rx_valid);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spim_mmio_top.sv
module spim_mmio_top #(
  parameter int DIV    = 3,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              busy;
  logic              xfer_done;
  logic              rise_evt;
  logic              fall_evt;
  logic              start;
  logic [DATA_W-1:0] start_data;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_valid;
  logic              rd_rxd_hit;
  logic              wr_txd_hit;

  spim_bus_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .we         (bus_we),
    .re         (bus_re),
    .rdata      (bus_rdata),
    .busy       (busy),
    .done       (xfer_done),
    .rx_byte    (rx_byte),
    .start      (start),
    .start_data (start_data),
    .rx_valid   (rx_valid),
    .rd_rxd     (rd_rxd_hit),
    .wr_txd     (wr_txd_hit)
  );

  spim_sclk_gen #(.DIV(DIV)) clk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (busy),
    .sclk     (spi_sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  spim_shift_core #(.DATA_W(DATA_W)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_data (start_data),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .miso       (spi_miso),
    .busy       (busy),
    .mosi       (spi_mosi),
    .done       (xfer_done),
    .rx_byte    (rx_byte)
  );
endmodule

// File: rtl/spim_mmio_chk.sv
module spim_mmio_chk #(
  parameter int DIV = 3
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic rx_valid,
  input logic rd_rxd,
  input logic wr_txd
);
  localparam int RW = $clog2(DIV + 2) + 1;

  logic          sclk_q;
  logic [RW-1:0] run;

  // Length of the current SCLK phase, measured independently of the divider.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      run    <= '0;
    end else begin
      sclk_q <= sclk;
      if (!busy)              run <= '0;
      else if (sclk != sclk_q) run <= RW'(1);
      else                    run <= run + 1'b1;
    end
  end

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r4_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (sclk != sclk_q)) |-> (run == RW'(DIV)));

  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !busy) |=> (busy && !sclk));

  a_r6_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rx_valid && !busy));

  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_txd && !done) |=> busy);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !done) |=> !rx_valid);

  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && done) |=> rx_valid);
endmodule

bind spim_mmio_top spim_mmio_chk #(.DIV(DIV)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (spi_sclk),
  .mosi     (spi_mosi),
  .busy     (busy),
  .done     (xfer_done),
  .rx_valid (rx_valid),
  .rd_rxd   (rd_rxd_hit),
  .wr_txd   (wr_txd_hit)
);

// File: tb/spim_mmio_top_tb_top.sv
module spim_mmio_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int XFER       = 16 * DIV;
  localparam logic [7:0] A_TXD = 8'h00;
  localparam logic [7:0] A_TXS = 8'h04;
  localparam logic [7:0] A_RXD = 8'h08;
  localparam logic [7:0] A_RXS = 8'h0C;
  localparam int NVEC = 5;
  // {byte sent by master, byte returned by slave}
  localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E, 16'h5AC3};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] slv_out = '0;
  logic [7:0] mosi_cap = '0;
  int         rise_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_mmio_top #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // Slave model: capture MOSI on rising SCLK, advance MISO after falling SCLK.
  always @(posedge spi_sclk) begin
    mosi_cap = {mosi_cap[6:0], spi_mosi};
    rise_cnt = rise_cnt + 1;
  end
  always @(negedge spi_sclk) begin
    slv_out  = {slv_out[6:0], 1'b0};
    spi_miso = slv_out[7];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic load_slave(input logic [7:0] b);
    slv_out  = b;
    spi_miso = b[7];
    mosi_cap = '0;
    rise_cnt = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_re = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sclk", spi_sclk, 0);
    check("R1 mosi", spi_mosi, 0);
    rd(A_TXS, v); check("R1 tx status", v, 1);
    rd(A_RXS, v); check("R1 rx status", v, 0);
    rd(A_RXD, v); check("R1 rx data", v, 0);

    // Vector table: one full exchange per entry
    for (int i = 0; i < NVEC; i++) begin
      load_slave(VEC[i][7:0]);
      wr(A_TXD, VEC[i][15:8]);
      repeat (XFER - 1) @(negedge clk);
      rd(A_TXS, v); check("R2 tx status busy before end", v, 0);
      rd(A_TXS, v); check("R6 tx status idle at end", v, 1);
      rd(A_RXS, v); check("R6 rx status set at end", v, 1);
      check("R3 mosi byte msb first", mosi_cap, VEC[i][15:8]);
      check("R4 eight rising edges", rise_cnt, 8);
      rd(8'h10, v); check("R10 unmapped read", v, 0);
      rd(A_RXS, v); check("R7 other reads keep flag", v, 1);
      rd(A_RXD, v); check("R5 received byte", v, {24'h0, VEC[i][7:0]});
      rd(A_RXS, v); check("R7 data read clears flag", v, 0);
    end

    // R4 serial clock phase timing
    load_slave(8'h96);
    wr(A_TXD, 8'h69);
    repeat (2) @(negedge clk); check("R4 low before first rise", spi_sclk, 0);
    @(negedge clk);            check("R4 first rise after DIV", spi_sclk, 1);
    repeat (2) @(negedge clk); check("R4 high phase", spi_sclk, 1);
    @(negedge clk);            check("R4 fall after DIV", spi_sclk, 0);
    repeat (XFER - 6) @(negedge clk);
    rd(A_RXD, v); check("R5 byte after phase test", v, 32'h96);

    // R8 write while shifting is ignored
    load_slave(8'h33);
    wr(A_TXD, 8'hC6);
    repeat (19) @(negedge clk);
    wr(A_TXD, 8'h11);
    repeat (XFER - 21) @(negedge clk);
    rd(A_TXS, v); check("R8 still busy at original end-1", v, 0);
    rd(A_TXS, v); check("R8 ends on original cycle", v, 1);
    check("R8 mosi unaffected", mosi_cap, 8'hC6);
    check("R8 rise count unaffected", rise_cnt, 8);

    // R9 completion and data read on the same edge (0x33 left unread)
    load_slave(8'h4B);
    wr(A_TXD, 8'h00);
    repeat (XFER - 1) @(negedge clk);
    rd(A_RXD, v); check("R9 read returns old byte", v, 32'h33);
    rd(A_RXS, v); check("R9 flag stays set", v, 1);
    rd(A_RXD, v); check("R9 new byte held", v, 32'h4B);
    rd(A_RXS, v); check("R9 flag cleared by next read", v, 0);

    // R10 misaligned reads and writes to other offsets
    rd(8'h02, v); check("R10 misaligned read", v, 0);
    wr(A_RXD, 8'h77);
    wr(8'h14, 8'h55);
    rd(A_TXS, v); check("R10 writes elsewhere start nothing", v, 1);
    check("R10 sclk idle", spi_sclk, 0);
    rd(A_RXS, v); check("R10 rx flag untouched", v, 0);

    summary();
    $finish;
  end
endmodule